// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers sixteen interrupt sources and steers each one onto one of up to eight processor interrupt lines. Five of the sources arrive from outside the chip as asynchronous wires. Each of those wires has its own conditioning setting, which picks whether the line is active high or active low and whether it is level or edge triggered. The other eleven sources are synchronous single-bit requests from on-chip logic. A request of this kind is held as pending from the first cycle it is high until software clears it.

Software reaches the block through a word-wide register port. Writes are strobed and reads are combinational on the word address. Through this port it programs a 4-bit routing field per source (a 3-bit output selector plus an enable) and a drive gate per output. It also sets the conditioning of the external lines, reads a 16-bit pending view per output, and clears latched sources with a write-one-to-clear word. Every register comes out of reset as zero, so nothing is routed and no output drives.

Register words (word address): 0 and 1 routing, 2 to 5 per-output status, 6 output gates, 7 clear, 8 external-line conditioning. Other addresses read as zero and ignore writes.

Top module: `irq_route_top`

## Requirements
- R1: After reset every register word (addresses 0 to 8) reads zero and `cpuIrq` is zero.
- R2: Source k owns nibble k%8 (bits 4·(k%8)+3 down to 4·(k%8)) of routing word k/8. Nibble bits [2:0] name the output and bit 3 enables the source. Both routing words read back exactly as written. Addresses above 8 read zero, and the clear word reads zero.
- R3: A source whose enable bit is 0 never appears in any status view and never drives an output. Its pending state is kept and shows up once it is enabled.
- R4: Status for output n sits in word 2+n/2, bits 16·(n%2)+15 down to 16·(n%2). Bit k there is 1 exactly when source k is pending, enabled, and routed to n.
- R5: Bit 16+n of word 6 gates output n. `cpuIrq[n]` is the registered OR of output n's status, ANDed with that gate, one cycle after the status.
- R6: Writing word 7 clears the latched pending state of every source whose bit is 1 in the written data. Sources with a 0 bit keep their state.
- R7: External line L (source L, L<5) uses bits 2L+1:2L of word 8. Bit 2L = 1 means active high and 0 means active low. Bit 2L+1 = 0 selects edge mode: a rise of the polarity-corrected input latches pending until cleared, and an input held active does not re-latch after a clear.
- R8: With bit 2L+1 = 1 (level mode) the pending state follows the corrected input. A clear has no lasting effect while the input stays active, and pending drops when the input goes inactive.
- R9: Internal source i (source 5+i) becomes pending on the cycle after `intSrc[i]` is high and stays pending until cleared.
- R10: An external input change passes two synchronizer flops. The status view changes after the third rising clock edge and `cpuIrq` after the fourth.
- R11: Writing zero to both routing words disables every source, and all outputs are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extIrq | input | 5 | Asynchronous external interrupt lines (sources 0 to 4) |
| intSrc | input | 11 | Synchronous internal requests (sources 5 to 15) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| cpuIrq | output | 8 | Processor interrupt outputs |

## Verification
The bench builds the block with its defaults: sixteen sources, eight outputs and five external lines. In that configuration it can sweep every pairing of a source with an output, checking all four status words and the output vector for each pairing. The same configuration lets it run all four conditioning modes on separate external lines. It also measures the synchronizer latency cycle by cycle and exercises the clear word with multi-bit masks.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int REG_ADDR_W = 4;
  localparam int REG_DATA_W = 32;
  localparam int NIB_W      = 4;
  localparam int SEL_W      = 3;

  typedef struct packed {
    logic                  wrRoute;
    logic [REG_ADDR_W-1:0] wordIdx;
    logic                  wrOutCtl;
    logic                  wrClear;
    logic                  wrCond;
    logic [REG_DATA_W-1:0] data;
  } regStrobes_t;

endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic activeHigh,
  input  logic levelMode,
  input  logic clrReq,
  output logic pending
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   pendQ;
  logic                   corr;

  // polarity correction after the last synchronizer flop
  assign corr = syncQ[SYNC_STAGES-1] ^ ~activeHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      prevQ <= corr;
      if (levelMode) pendQ <= corr;
      else           pendQ <= (pendQ & ~clrReq) | (corr & ~prevQ);
    end
  end

  assign pending = pendQ;

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_OUT     = 8,
  parameter int NUM_EXT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobes_t                strb,
  input  logic [NUM_EXT-1:0]         extIrq,
  input  logic [NUM_SRC-NUM_EXT-1:0] intSrc,
  output logic [NUM_SRC*NIB_W-1:0]   routeCfg,
  output logic [NUM_OUT-1:0]         drvEn,
  output logic [2*NUM_EXT-1:0]       condCfg,
  output logic [NUM_OUT*NUM_SRC-1:0] statusFlat,
  output logic [NUM_SRC-1:0]         pendVec,
  output logic [NUM_OUT-1:0]         cpuIrq
);

  localparam int NUM_INT     = NUM_SRC - NUM_EXT;
  localparam int ROUTE_BITS  = NUM_SRC * NIB_W;
  localparam int ROUTE_WORDS = ROUTE_BITS / REG_DATA_W;

  logic [ROUTE_BITS-1:0]  routeQ;
  logic [NUM_OUT-1:0]     drvQ;
  logic [2*NUM_EXT-1:0]   condQ;
  logic [NUM_SRC-1:0]     clrVec;
  logic [NUM_INT-1:0]     intPendQ;
  logic [NUM_OUT-1:0]     cpuQ;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeQ <= '0;
      drvQ   <= '0;
      condQ  <= '0;
    end else begin
      for (int w = 0; w < ROUTE_WORDS; w++) begin
        if (strb.wrRoute && strb.wordIdx == REG_ADDR_W'(w))
          routeQ[w*REG_DATA_W +: REG_DATA_W] <= strb.data;
      end
      if (strb.wrOutCtl) drvQ  <= strb.data[16 +: NUM_OUT];
      if (strb.wrCond)   condQ <= strb.data[2*NUM_EXT-1:0];
    end
  end

  assign clrVec = strb.wrClear ? strb.data[NUM_SRC-1:0] : '0;

  // external lines: synchronize, condition, latch
  for (genvar l = 0; l < NUM_EXT; l++) begin : gExt
    irq_ext_cond #(.SYNC_STAGES(SYNC_STAGES)) uCond (
      .clk       (clk),
      .rstN      (rstN),
      .rawIn     (extIrq[l]),
      .activeHigh(condQ[2*l]),
      .levelMode (condQ[2*l+1]),
      .clrReq    (clrVec[l]),
      .pending   (pendVec[l])
    );
  end

  // internal requests: sticky until cleared
  for (genvar i = 0; i < NUM_INT; i++) begin : gInt
    always_ff @(posedge clk) begin
      if (!rstN) intPendQ[i] <= 1'b0;
      else       intPendQ[i] <= (intPendQ[i] & ~clrVec[NUM_EXT+i]) | intSrc[i];
    end
    assign pendVec[NUM_EXT+i] = intPendQ[i];
  end

  // routing matrix: status per output
  for (genvar n = 0; n < NUM_OUT; n++) begin : gOut
    for (genvar k = 0; k < NUM_SRC; k++) begin : gSrc
      assign statusFlat[n*NUM_SRC+k] = pendVec[k]
                                     & routeQ[k*NIB_W+SEL_W]
                                     & (routeQ[k*NIB_W +: SEL_W] == SEL_W'(n));
    end
    always_ff @(posedge clk) begin
      if (!rstN) cpuQ[n] <= 1'b0;
      else       cpuQ[n] <= (|statusFlat[n*NUM_SRC +: NUM_SRC]) & drvQ[n];
    end
  end

  assign routeCfg = routeQ;
  assign drvEn    = drvQ;
  assign condCfg  = condQ;
  assign cpuIrq   = cpuQ;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8,
  parameter int NUM_EXT = 5
) (
  input  logic                       regWrEn,
  input  logic [REG_ADDR_W-1:0]      regAddr,
  input  logic [REG_DATA_W-1:0]      regWrData,
  input  logic [NUM_SRC*NIB_W-1:0]   routeCfg,
  input  logic [NUM_OUT-1:0]         drvEn,
  input  logic [2*NUM_EXT-1:0]       condCfg,
  input  logic [NUM_OUT*NUM_SRC-1:0] statusFlat,
  output regStrobes_t                strb,
  output logic [REG_DATA_W-1:0]      regRdData
);

  localparam int ROUTE_WORDS = (NUM_SRC * NIB_W) / REG_DATA_W;
  localparam int STAT_BASE   = ROUTE_WORDS;
  localparam int STAT_WORDS  = (NUM_OUT + 1) / 2;
  localparam int OUT_CTL_A   = STAT_BASE + STAT_WORDS;
  localparam int CLEAR_A     = OUT_CTL_A + 1;
  localparam int COND_A      = CLEAR_A + 1;

  // write decode into strobes
  always_comb begin
    strb          = '0;
    strb.data     = regWrData;
    strb.wordIdx  = regAddr;
    strb.wrRoute  = regWrEn && (regAddr < REG_ADDR_W'(ROUTE_WORDS));
    strb.wrOutCtl = regWrEn && (regAddr == REG_ADDR_W'(OUT_CTL_A));
    strb.wrClear  = regWrEn && (regAddr == REG_ADDR_W'(CLEAR_A));
    strb.wrCond   = regWrEn && (regAddr == REG_ADDR_W'(COND_A));
  end

  // read mux
  always_comb begin
    regRdData = '0;
    for (int w = 0; w < ROUTE_WORDS; w++) begin
      if (regAddr == REG_ADDR_W'(w))
        regRdData = routeCfg[w*REG_DATA_W +: REG_DATA_W];
    end
    for (int s = 0; s < STAT_WORDS; s++) begin
      if (regAddr == REG_ADDR_W'(STAT_BASE + s)) begin
        for (int h = 0; h < 2; h++) begin
          if (2*s + h < NUM_OUT)
            regRdData[16*h +: NUM_SRC] = statusFlat[(2*s+h)*NUM_SRC +: NUM_SRC];
        end
      end
    end
    if (regAddr == REG_ADDR_W'(OUT_CTL_A)) regRdData[16 +: NUM_OUT] = drvEn;
    if (regAddr == REG_ADDR_W'(COND_A))    regRdData[2*NUM_EXT-1:0] = condCfg;
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_OUT     = 8,
  parameter int NUM_EXT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extIrq,
  input  logic [NUM_SRC-NUM_EXT-1:0] intSrc,
  input  logic                       regWrEn,
  input  logic [REG_ADDR_W-1:0]      regAddr,
  input  logic [REG_DATA_W-1:0]      regWrData,
  output logic [REG_DATA_W-1:0]      regRdData,
  output logic [NUM_OUT-1:0]         cpuIrq
);

  regStrobes_t                strb;
  logic [NUM_SRC*NIB_W-1:0]   routeCfg;
  logic [NUM_OUT-1:0]         drvEn;
  logic [2*NUM_EXT-1:0]       condCfg;
  logic [NUM_OUT*NUM_SRC-1:0] statusFlat;
  logic [NUM_SRC-1:0]         pendVec;

  irq_route_ctrl #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_EXT(NUM_EXT)) uCtrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .routeCfg  (routeCfg),
    .drvEn     (drvEn),
    .condCfg   (condCfg),
    .statusFlat(statusFlat),
    .strb      (strb),
    .regRdData (regRdData)
  );

  irq_route_dp #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_EXT(NUM_EXT), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .extIrq    (extIrq),
    .intSrc    (intSrc),
    .routeCfg  (routeCfg),
    .drvEn     (drvEn),
    .condCfg   (condCfg),
    .statusFlat(statusFlat),
    .pendVec   (pendVec),
    .cpuIrq    (cpuIrq)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 8,
  parameter int NUM_EXT = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_SRC-NUM_EXT-1:0] intSrc,
  input logic [NUM_OUT-1:0]         cpuIrq,
  input logic [NUM_SRC*NIB_W-1:0]   routeCfg,
  input logic [NUM_OUT-1:0]         drvEn,
  input logic [NUM_OUT*NUM_SRC-1:0] statusFlat,
  input logic [NUM_SRC-1:0]         pendVec,
  input regStrobes_t                strb
);

  logic [NUM_SRC-1:0] enMask;
  for (genvar k = 0; k < NUM_SRC; k++) begin : gEn
    assign enMask[k] = routeCfg[k*NIB_W+SEL_W];
  end

  // R5: an output only rises when its gate was set on the previous cycle
  assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq & ~$past(drvEn)) == '0);

  // R11: nothing routed means all outputs low next cycle
  assert_all_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    (routeCfg == '0) |=> (cpuIrq == '0));

  for (genvar n = 0; n < NUM_OUT; n++) begin : gOutChk
    // R3: disabled sources never reach a status view
    assert_disabled_hidden_R3: assert property (@(posedge clk) disable iff (!rstN)
      (statusFlat[n*NUM_SRC +: NUM_SRC] & ~enMask) == '0);
  end

  for (genvar i = 0; i < NUM_SRC-NUM_EXT; i++) begin : gIntChk
    // R9: an internal request is pending on the next cycle
    assert_int_latch_R9: assert property (@(posedge clk) disable iff (!rstN)
      intSrc[i] |=> pendVec[NUM_EXT+i]);
    // R6: a clear with the request low empties the latch
    assert_int_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrClear && strb.data[NUM_EXT+i] && !intSrc[i]) |=> !pendVec[NUM_EXT+i]);
  end

endmodule

bind irq_route_top irq_route_chk #(
  .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_EXT(NUM_EXT)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .intSrc    (intSrc),
  .cpuIrq    (cpuIrq),
  .routeCfg  (routeCfg),
  .drvEn     (drvEn),
  .statusFlat(statusFlat),
  .pendVec   (pendVec),
  .strb      (strb)
);

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;

  localparam int NS = 16;
  localparam int NO = 8;
  localparam int NE = 5;
  localparam int NI = NS - NE;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NE-1:0] extIrq;
  logic [NI-1:0] intSrc;
  logic          regWrEn;
  logic [3:0]    regAddr;
  logic [31:0]   regWrData;
  logic [31:0]   regRdData;
  logic [NO-1:0] cpuIrq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irq_route_top dut (
    .clk(clk), .rstN(rstN), .extIrq(extIrq), .intSrc(intSrc),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a[3:0]; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    regAddr = a[3:0];
    #1;
    d = regRdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; extIrq = '0; intSrc = '0;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a <= 8; a++) begin
      rd(a, d); chk("R1 reset word", d, 32'h0);
    end
    chk("R1 reset outputs", 32'(cpuIrq), 32'h0);

    // R2: routing readback and address map edges
    wr(0, 32'h89ABCDEF);
    wr(1, 32'h12345678);
    rd(0, d); chk("R2 route lo", d, 32'h89ABCDEF);
    rd(1, d); chk("R2 route hi", d, 32'h12345678);
    wr(12, 32'hFFFFFFFF);
    rd(12, d); chk("R2 unmapped", d, 32'h0);
    rd(7, d);  chk("R2 clear reads 0", d, 32'h0);
    wr(0, 32'h0); wr(1, 32'h0);

    // common setup: all external lines level, active high; all gates on
    wr(8, 32'h3FF);
    wr(6, 32'h00FF0000);
    rd(6, d); chk("R5 gate readback", d, 32'h00FF0000);
    idle(4);
    wr(7, 32'hFFFF);
    idle(2);

    // R4 R5 R8 R9: every source to every output
    for (int k = 0; k < NS; k++) begin
      for (int n = 0; n < NO; n++) begin
        logic [31:0] v;
        v = (32'h8 | 32'(n)) << (4 * (k % 8));
        wr(0, (k < 8) ? v : 32'h0);
        wr(1, (k < 8) ? 32'h0 : v);
        if (k < NE) extIrq[k] = 1'b1;
        else begin
          intSrc[k-NE] = 1'b1;
          @(negedge clk);
          intSrc[k-NE] = 1'b0;
        end
        idle(5);
        for (int w = 0; w < 4; w++) begin
          logic [31:0] e;
          e = (w == n / 2) ? ((32'h1 << k) << (16 * (n % 2))) : 32'h0;
          rd(2 + w, d); chk("R4 status view", d, e);
        end
        chk("R5 routed output", 32'(cpuIrq), 32'h1 << n);
        if (k < NE) extIrq[k] = 1'b0;
        else wr(7, 32'h1 << k);
        idle(5);
        chk((k < NE) ? "R8 level release" : "R9 cleared output", 32'(cpuIrq), 32'h0);
        rd(2 + n / 2, d); chk("R4 status after release", d, 32'h0);
      end
    end

    // R3: disabled source keeps pending but stays hidden
    wr(0, 32'h02000000);          // source 6 -> output 2, enable off
    wr(1, 32'h0);
    intSrc[1] = 1'b1; @(negedge clk); intSrc[1] = 1'b0;
    idle(3);
    rd(3, d); chk("R3 disabled hidden", d, 32'h0);
    chk("R3 disabled no output", 32'(cpuIrq), 32'h0);
    wr(0, 32'h0A000000);
    rd(3, d); chk("R3 enabled shows pending", d, 32'h40);
    idle(1);
    chk("R3 enabled output", 32'(cpuIrq), 32'h04);

    // R5: output gate
    wr(6, 32'h0);
    idle(1);
    chk("R5 gate off", 32'(cpuIrq), 32'h0);
    rd(3, d); chk("R5 status ungated", d, 32'h40);
    wr(6, 32'h1 << 17);
    idle(1);
    chk("R5 other gate", 32'(cpuIrq), 32'h0);
    wr(6, 32'h1 << 18);
    idle(1);
    chk("R5 own gate", 32'(cpuIrq), 32'h04);
    wr(6, 32'h00FF0000);
    wr(7, 32'hFFFF);

    // R6: multi-bit clear
    wr(0, 32'h88800000);          // sources 5,6,7 -> output 0
    intSrc[2:0] = 3'b111; @(negedge clk); intSrc[2:0] = 3'b000;
    idle(1);
    rd(2, d); chk("R9 three pending", d, 32'hE0);
    wr(7, (32'h1 << 5) | (32'h1 << 7));
    rd(2, d); chk("R6 partial clear", d, 32'h40);
    idle(1);
    chk("R6 survivor drives", 32'(cpuIrq), 32'h01);
    wr(7, 32'h1 << 6);
    idle(1);
    chk("R6 final clear", 32'(cpuIrq), 32'h0);

    // R7: edge, active high on line 2
    wr(0, 32'h00000800);
    wr(8, 32'h3DF);
    idle(4);
    wr(7, 32'hFFFF);
    idle(1);
    rd(2, d); chk("R7 edge idle", d, 32'h0);
    extIrq[2] = 1'b1; @(negedge clk); extIrq[2] = 1'b0;
    idle(5);
    rd(2, d); chk("R7 edge latched", d, 32'h4);
    chk("R7 edge output", 32'(cpuIrq), 32'h01);
    wr(7, 32'h4);
    idle(2);
    rd(2, d); chk("R7 edge cleared", d, 32'h0);
    extIrq[2] = 1'b1;
    idle(5);
    wr(7, 32'h4);
    idle(3);
    rd(2, d); chk("R7 held input no relatch", d, 32'h0);
    extIrq[2] = 1'b0;
    idle(4);

    // R7: edge, active low on line 3
    wr(0, 32'h00009000);          // source 3 -> output 1
    extIrq[3] = 1'b1;
    idle(4);
    wr(8, 32'h31F);
    idle(4);
    wr(7, 32'hFFFF);
    idle(2);
    rd(2, d); chk("R7 low-active idle", d, 32'h0);
    extIrq[3] = 1'b0;
    idle(5);
    rd(2, d); chk("R7 falling latched", d, 32'h00080000);
    chk("R7 falling output", 32'(cpuIrq), 32'h02);
    extIrq[3] = 1'b1;
    idle(4);
    rd(2, d); chk("R7 stays after release", d, 32'h00080000);
    wr(7, 32'h8);
    idle(2);
    rd(2, d); chk("R7 low-active cleared", d, 32'h0);

    // R8: level, active low on line 0
    extIrq[0] = 1'b1;
    wr(8, 32'h31E);
    wr(0, 32'h0000000C);          // source 0 -> output 4
    idle(4);
    rd(4, d); chk("R8 inactive", d, 32'h0);
    extIrq[0] = 1'b0;
    idle(4);
    rd(4, d); chk("R8 active low pending", d, 32'h1);
    wr(7, 32'h1);
    idle(2);
    rd(4, d); chk("R8 clear ineffective", d, 32'h1);
    chk("R8 output held", 32'(cpuIrq), 32'h10);
    extIrq[0] = 1'b1;
    idle(4);
    rd(4, d); chk("R8 drops", d, 32'h0);
    chk("R8 output drops", 32'(cpuIrq), 32'h0);

    // R10: synchronizer latency on line 1 (level, active high)
    wr(0, 32'h00000080);          // source 1 -> output 0
    idle(2);
    extIrq[1] = 1'b1;
    @(negedge clk); rd(2, d); chk("R10 after edge 1", d, 32'h0);
    @(negedge clk); rd(2, d); chk("R10 after edge 2", d, 32'h0);
    @(negedge clk); rd(2, d); chk("R10 after edge 3", d, 32'h2);
    chk("R10 output not yet", 32'(cpuIrq), 32'h0);
    @(negedge clk); chk("R10 output after edge 4", 32'(cpuIrq), 32'h01);

    // R11: zero both routing words
    wr(1, 32'h0);
    wr(0, 32'h0);
    idle(1);
    chk("R11 all off", 32'(cpuIrq), 32'h0);
    rd(2, d); chk("R11 status empty", d, 32'h0);
    extIrq[1] = 1'b0;
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule